// File: doc/BRIEF.md
# Branch and Jump Next-PC Resolver

This block works out where control goes after a branch or jump instruction once its delay slot has run. It receives the PC of the control-transfer instruction, the 32-bit instruction word and every operand the condition may need. Those operands are the two source register values, the floating-point control/status word, a DSP position count and a flag that says whether the DSP extension is present. The block decodes the instruction, evaluates the condition and forms the target. It returns the resolved next PC, whether the transfer was taken, a link write request (register index and value), and a fault or invalid indication.

It is meant for an exception handler path or a slow-path unit that has to replay a branch whose delay slot trapped. The register file reads, fetch and squashing of the delay slot of likely forms all stay outside the block. The likely forms resolve their target exactly like the plain forms. One register stage sits between request and result. A parameter can remove the bit-test and DSP-threshold branches, and those opcodes are then reported as invalid.

Top module: `branch_npc_resolver`

## Requirements
- R1: If pc_i[1:0] is nonzero, only misalign_o is raised. next_pc_o equals pc_i, and taken_o and link_we_o are 0, whatever the instruction.
- R2: A conditional branch that is taken yields pc+4 plus the sign-extended 16-bit immediate (instr[15:0]) shifted left by 2. One that is not taken yields pc+8. Both set taken_o to match.
- R3: Opcodes 4 and 20 branch when rs equals rt and opcodes 5 and 21 branch when they differ, over the full 64 bits. Opcodes 6 and 22 branch when rs is at most zero and opcodes 7 and 23 when it is above zero, both as signed values.
- R4: Opcode 1 takes its condition from rt (instr[20:16]). Codes 0 and 2 branch when rs is below zero and codes 1 and 3 when it is at least zero (signed). Codes 16, 18, 17 and 19 do the same and also link pc+8 into register 31, whether or not the branch is taken.
- R5: Opcodes 2 and 3 jump to {upper 4 bits of pc+4, instr[25:0], 2'b00}. Opcode 3 also links pc+8 into register 31.
- R6: Opcode 0 with function field (instr[5:0]) 8 jumps to the low 32 bits of rs. Function field 9 does the same and links pc+8 into the register named by instr[15:11].
- R7: Opcode 17 with instr[25:21] equal to 8 tests one status bit, with cc = instr[20:18]. The bit is 23 when cc is 0 and 24+cc otherwise, so bit 24 is never tested. instr[16]=1 branches when the bit is set and instr[16]=0 branches when it is clear.
- R8: Opcode 1 with rt code 28 branches when dsp_pos_i is at least 32. When dsp_avail_i is 0 it instead raises dsp_fault_o only, with next_pc_o equal to pc_i and no link.
- R9: Opcodes 50 and 58 test rs bit rt (instr[20:16]), and opcodes 54 and 62 test rs bit rt+32. Opcodes 50 and 54 branch when that bit is 0, and opcodes 58 and 62 branch when it is 1.
- R10: Any other encoding raises invalid_o only, with next_pc_o equal to pc+4, taken_o 0 and no link. With EXT_EN=0 this also covers opcodes 50, 54, 58 and 62 and rt code 28 of opcode 1.
- R11: valid_o follows valid_i one cycle later. Result outputs load only on cycles where valid_i is 1 and hold otherwise. Reset clears everything to 0.
- R12: link_we_o is raised only for linking forms that do not fault. When it is low, link_idx_o and link_val_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| pc_i | input | 32 | PC of the branch or jump |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 64 | Value of source register rs |
| rt_val_i | input | 64 | Value of source register rt |
| fcsr_i | input | 32 | Floating-point control/status word |
| dsp_pos_i | input | 6 | DSP position count |
| dsp_avail_i | input | 1 | DSP extension present |
| valid_o | output | 1 | Result strobe |
| next_pc_o | output | 32 | Resolved next PC |
| taken_o | output | 1 | Control transferred to target |
| link_we_o | output | 1 | Link write request |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 32 | Link value |
| misalign_o | output | 1 | PC misaligned fault |
| dsp_fault_o | output | 1 | DSP branch without DSP extension |
| invalid_o | output | 1 | Not a supported branch or jump |

## Verification
The assertions assume that valid_i and the operand inputs are stable across each rising edge and already known once reset is released. They also assume that at most one fault class can apply to a request, with misalignment taking precedence. The bench drives every input on the falling edge and holds valid_i low through reset. It issues requests back to back and then idles so that both the hold and the pipeline timing are exercised. Operand values are chosen to straddle each decision point: zero, sign boundaries, differences only in the upper word, the skipped status bit 24 and a position count of 31 against 32.

// File: rtl/bnr_pkg.sv
package bnr_pkg;
  typedef enum logic [1:0] {K_NONE, K_JREG, K_JABS, K_COND} kind_e;
  typedef enum logic [3:0] {
    C_LTZ, C_GEZ, C_LEZ, C_GTZ, C_EQ, C_NE, C_FPF, C_FPT, C_POS, C_BCLR, C_BSET
  } cond_e;

  typedef struct packed {
    kind_e      kind;
    cond_e      cond;
    logic       link;
    logic       link_rd;
    logic       dsp;
    logic [5:0] bit_idx;
  } dec_t;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_REGIMM  = 6'd1;
  localparam logic [5:0] OP_J       = 6'd2;
  localparam logic [5:0] OP_JAL     = 6'd3;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] OP_BLEZ    = 6'd6;
  localparam logic [5:0] OP_BGTZ    = 6'd7;
  localparam logic [5:0] OP_COP1    = 6'd17;
  localparam logic [5:0] OP_BEQL    = 6'd20;
  localparam logic [5:0] OP_BNEL    = 6'd21;
  localparam logic [5:0] OP_BLEZL   = 6'd22;
  localparam logic [5:0] OP_BGTZL   = 6'd23;
  localparam logic [5:0] OP_TST0_LO = 6'd50;
  localparam logic [5:0] OP_TST0_HI = 6'd54;
  localparam logic [5:0] OP_TST1_LO = 6'd58;
  localparam logic [5:0] OP_TST1_HI = 6'd62;

  localparam logic [5:0] FN_JR      = 6'd8;
  localparam logic [5:0] FN_JALR    = 6'd9;
  localparam logic [4:0] RS_BC1     = 5'd8;
  localparam logic [4:0] RT_POSGE   = 5'd28;
  localparam logic [4:0] LINK_REG   = 5'd31;

  localparam int unsigned FP_CC0_BIT  = 23;
  localparam int unsigned FP_CCN_BASE = 24;
endpackage

// File: rtl/bnr_decode.sv
module bnr_decode
  import bnr_pkg::*;
#(
  parameter bit EXT_EN = 1'b1
) (
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic [5:0] op, fn;
  logic [4:0] rsf, rt;
  logic [2:0] cc;
  logic       unused_bits;

  assign op  = instr_i[31:26];
  assign rsf = instr_i[25:21];
  assign rt  = instr_i[20:16];
  assign fn  = instr_i[5:0];
  assign cc  = rt[4:2];
  assign unused_bits = ^instr_i[15:6];

  dec_t ext_dec;
  logic ext_hit;

  generate
    if (EXT_EN) begin : g_ext
      always_comb begin
        ext_hit = 1'b0;
        ext_dec = '0;
        ext_dec.kind = K_COND;
        case (op)
          OP_TST0_LO: begin ext_hit = 1'b1; ext_dec.cond = C_BCLR; ext_dec.bit_idx = {1'b0, rt}; end
          OP_TST0_HI: begin ext_hit = 1'b1; ext_dec.cond = C_BCLR; ext_dec.bit_idx = {1'b1, rt}; end
          OP_TST1_LO: begin ext_hit = 1'b1; ext_dec.cond = C_BSET; ext_dec.bit_idx = {1'b0, rt}; end
          OP_TST1_HI: begin ext_hit = 1'b1; ext_dec.cond = C_BSET; ext_dec.bit_idx = {1'b1, rt}; end
          OP_REGIMM: if (rt == RT_POSGE) begin
            ext_hit = 1'b1; ext_dec.cond = C_POS; ext_dec.dsp = 1'b1;
          end
          default: ;
        endcase
      end
    end else begin : g_noext
      assign ext_hit = 1'b0;
      assign ext_dec = '0;
    end
  endgenerate

  always_comb begin
    dec_o = '0;
    case (op)
      OP_SPECIAL: begin
        if (fn == FN_JR) dec_o.kind = K_JREG;
        else if (fn == FN_JALR) begin
          dec_o.kind = K_JREG; dec_o.link = 1'b1; dec_o.link_rd = 1'b1;
        end
      end
      OP_REGIMM: begin
        case (rt)
          5'd0, 5'd2:   begin dec_o.kind = K_COND; dec_o.cond = C_LTZ; end
          5'd1, 5'd3:   begin dec_o.kind = K_COND; dec_o.cond = C_GEZ; end
          5'd16, 5'd18: begin dec_o.kind = K_COND; dec_o.cond = C_LTZ; dec_o.link = 1'b1; end
          5'd17, 5'd19: begin dec_o.kind = K_COND; dec_o.cond = C_GEZ; dec_o.link = 1'b1; end
          default: ;
        endcase
      end
      OP_J:   dec_o.kind = K_JABS;
      OP_JAL: begin dec_o.kind = K_JABS; dec_o.link = 1'b1; end
      OP_BEQ, OP_BEQL:   begin dec_o.kind = K_COND; dec_o.cond = C_EQ;  end
      OP_BNE, OP_BNEL:   begin dec_o.kind = K_COND; dec_o.cond = C_NE;  end
      OP_BLEZ, OP_BLEZL: begin dec_o.kind = K_COND; dec_o.cond = C_LEZ; end
      OP_BGTZ, OP_BGTZL: begin dec_o.kind = K_COND; dec_o.cond = C_GTZ; end
      OP_COP1: if (rsf == RS_BC1) begin
        dec_o.kind = K_COND;
        dec_o.cond = rt[0] ? C_FPT : C_FPF;
        // status bit 24 is skipped: cc0 -> 23, ccN -> 24+N
        dec_o.bit_idx = (cc == 3'd0) ? 6'(FP_CC0_BIT) : 6'(FP_CCN_BASE) + {3'd0, cc};
      end
      default: ;
    endcase
    if (ext_hit) dec_o = ext_dec;
  end
endmodule

// File: rtl/bnr_cond.sv
module bnr_cond
  import bnr_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned FCSR_W   = 32,
  parameter int unsigned POS_W    = 6,
  parameter int unsigned POS_THR  = 32
) (
  input  dec_t              dec_i,
  input  logic [XLEN-1:0]   rs_i,
  input  logic [XLEN-1:0]   rt_i,
  input  logic [FCSR_W-1:0] fcsr_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic              taken_o
);
  localparam int unsigned FIDX_W = $clog2(FCSR_W);
  localparam int unsigned XIDX_W = $clog2(XLEN);

  logic neg, zero, fbit, xbit;
  assign neg  = rs_i[XLEN-1];
  assign zero = (rs_i == '0);
  assign fbit = fcsr_i[dec_i.bit_idx[FIDX_W-1:0]];
  assign xbit = rs_i[dec_i.bit_idx[XIDX_W-1:0]];

  always_comb begin
    case (dec_i.cond)
      C_LTZ:   taken_o = neg;
      C_GEZ:   taken_o = !neg;
      C_LEZ:   taken_o = neg || zero;
      C_GTZ:   taken_o = !neg && !zero;
      C_EQ:    taken_o = (rs_i == rt_i);
      C_NE:    taken_o = (rs_i != rt_i);
      C_FPF:   taken_o = !fbit;
      C_FPT:   taken_o = fbit;
      C_POS:   taken_o = (pos_i >= POS_W'(POS_THR));
      C_BCLR:  taken_o = !xbit;
      C_BSET:  taken_o = xbit;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bnr_target.sv
module bnr_target #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned JT_W  = 26
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [31:0]     instr_i,
  input  logic [PC_W-1:0] rs_i,
  output logic [PC_W-1:0] seq_o,
  output logic [PC_W-1:0] fall_o,
  output logic [PC_W-1:0] br_o,
  output logic [PC_W-1:0] jabs_o,
  output logic [PC_W-1:0] jreg_o
);
  localparam int unsigned REGION_LSB = JT_W + 2;

  logic [IMM_W-1:0] imm;
  logic [PC_W-1:0]  off;
  logic             unused_hi;

  assign imm    = instr_i[IMM_W-1:0];
  assign off    = {{(PC_W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
  assign seq_o  = pc_i + PC_W'(4);
  assign fall_o = pc_i + PC_W'(8);
  assign br_o   = seq_o + off;
  assign jabs_o = {seq_o[PC_W-1:REGION_LSB], instr_i[JT_W-1:0], 2'b00};
  assign jreg_o = rs_i;
  assign unused_hi = ^instr_i[31:JT_W];
endmodule

// File: rtl/branch_npc_resolver.sv
module branch_npc_resolver
  import bnr_pkg::*;
#(
  parameter bit          EXT_EN  = 1'b1,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned XLEN    = 64,
  parameter int unsigned FCSR_W  = 32,
  parameter int unsigned POS_W   = 6,
  parameter int unsigned POS_THR = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [FCSR_W-1:0] fcsr_i,
  input  logic [POS_W-1:0]  dsp_pos_i,
  input  logic              dsp_avail_i,
  output logic              valid_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [4:0]        link_idx_o,
  output logic [PC_W-1:0]   link_val_o,
  output logic              misalign_o,
  output logic              dsp_fault_o,
  output logic              invalid_o
);
  dec_t            dec;
  logic            cond_tk;
  logic [PC_W-1:0] seq, fall, br, jabs, jreg;

  bnr_decode #(.EXT_EN(EXT_EN)) u_dec (.instr_i(instr_i), .dec_o(dec));

  bnr_cond #(
    .XLEN(XLEN), .FCSR_W(FCSR_W), .POS_W(POS_W), .POS_THR(POS_THR)
  ) u_cond (
    .dec_i(dec), .rs_i(rs_val_i), .rt_i(rt_val_i),
    .fcsr_i(fcsr_i), .pos_i(dsp_pos_i), .taken_o(cond_tk)
  );

  bnr_target #(.PC_W(PC_W)) u_tgt (
    .pc_i(pc_i), .instr_i(instr_i), .rs_i(rs_val_i[PC_W-1:0]),
    .seq_o(seq), .fall_o(fall), .br_o(br), .jabs_o(jabs), .jreg_o(jreg)
  );

  logic            n_mis, n_dspf, n_inv, n_tk, n_lwe;
  logic [PC_W-1:0] n_pc, n_lval;
  logic [4:0]      n_lidx;

  always_comb begin
    n_mis  = 1'b0;
    n_dspf = 1'b0;
    n_inv  = 1'b0;
    n_tk   = 1'b0;
    n_pc   = pc_i;
    if (|pc_i[1:0]) begin
      n_mis = 1'b1;
    end else if (dec.kind == K_NONE) begin
      n_inv = 1'b1;
      n_pc  = seq;
    end else if (dec.dsp && !dsp_avail_i) begin
      n_dspf = 1'b1;
    end else begin
      case (dec.kind)
        K_JREG:  begin n_tk = 1'b1; n_pc = jreg; end
        K_JABS:  begin n_tk = 1'b1; n_pc = jabs; end
        default: begin n_tk = cond_tk; n_pc = cond_tk ? br : fall; end
      endcase
    end
    n_lwe  = dec.link && !(n_mis || n_dspf || n_inv);
    n_lidx = n_lwe ? (dec.link_rd ? instr_i[15:11] : LINK_REG) : 5'd0;
    n_lval = n_lwe ? fall : '0;
  end

  logic [PC_W-1:0] pc_q;
  logic            arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      arm_q       <= 1'b0;
      pc_q        <= '0;
      next_pc_o   <= '0;
      taken_o     <= 1'b0;
      link_we_o   <= 1'b0;
      link_idx_o  <= '0;
      link_val_o  <= '0;
      misalign_o  <= 1'b0;
      dsp_fault_o <= 1'b0;
      invalid_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      arm_q   <= 1'b1;
      if (valid_i) begin
        pc_q        <= pc_i;
        next_pc_o   <= n_pc;
        taken_o     <= n_tk;
        link_we_o   <= n_lwe;
        link_idx_o  <= n_lidx;
        link_val_o  <= n_lval;
        misalign_o  <= n_mis;
        dsp_fault_o <= n_dspf;
        invalid_o   <= n_inv;
      end
    end
  end

  logic any_fault;
  assign any_fault = misalign_o || dsp_fault_o || invalid_o;

  p_valid_lat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |-> (valid_o == $past(valid_i)));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q && !$past(valid_i)) |-> ($stable(next_pc_o) && $stable(link_we_o)));

  p_fault_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot0({misalign_o, dsp_fault_o, invalid_o}));

  p_fault_no_link_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && any_fault) |-> (!link_we_o && !taken_o));

  p_fall_pc8_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !any_fault && !taken_o) |-> (next_pc_o == pc_q + PC_W'(8)));

  p_misalign_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && misalign_o) |-> (next_pc_o == pc_q));
endmodule

// File: tb/branch_npc_resolver_tb.sv
module branch_npc_resolver_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        valid_i = 1'b0;
  logic [31:0] pc_i = '0, instr_i = '0, fcsr_i = '0;
  logic [63:0] rs_i = '0, rt_i = '0;
  logic [5:0]  pos_i = '0;
  logic        dav_i = 1'b1;

  logic        va, tka, lwea, misa, dspfa, inva;
  logic [31:0] npca, lvala;
  logic [4:0]  lidxa;
  logic        vb, tkb, lweb, misb, dspfb, invb;
  logic [31:0] npcb, lvalb;
  logic [4:0]  lidxb;

  branch_npc_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .pc_i(pc_i), .instr_i(instr_i),
    .rs_val_i(rs_i), .rt_val_i(rt_i), .fcsr_i(fcsr_i), .dsp_pos_i(pos_i),
    .dsp_avail_i(dav_i), .valid_o(va), .next_pc_o(npca), .taken_o(tka),
    .link_we_o(lwea), .link_idx_o(lidxa), .link_val_o(lvala),
    .misalign_o(misa), .dsp_fault_o(dspfa), .invalid_o(inva));

  branch_npc_resolver #(.EXT_EN(1'b0)) u_dut_noext (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .pc_i(pc_i), .instr_i(instr_i),
    .rs_val_i(rs_i), .rt_val_i(rt_i), .fcsr_i(fcsr_i), .dsp_pos_i(pos_i),
    .dsp_avail_i(dav_i), .valid_o(vb), .next_pc_o(npcb), .taken_o(tkb),
    .link_we_o(lweb), .link_idx_o(lidxb), .link_val_o(lvalb),
    .misalign_o(misb), .dsp_fault_o(dspfb), .invalid_o(invb));

  typedef struct packed {
    logic [31:0] npc;
    logic        tk;
    logic        lwe;
    logic [4:0]  lidx;
    logic [31:0] lval;
    logic        mis;
    logic        dspf;
    logic        inv;
  } exp_t;

  exp_t  qa[$];
  exp_t  qb[$];
  string qt[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic exp_t model(input bit ext, input logic [31:0] pc, input logic [31:0] ins,
                                 input logic [63:0] rs, input logic [63:0] rt,
                                 input logic [31:0] fc, input logic [5:0] pos, input bit dav);
    exp_t e;
    int kind;
    bit c, lk, dsp;
    int li, fb;
    logic [5:0] op;
    logic [4:0] rf, tf;
    logic [31:0] off;
    e = '0; kind = 0; c = 0; lk = 0; dsp = 0; li = 31;
    op = ins[31:26]; rf = ins[25:21]; tf = ins[20:16];
    off = {{14{ins[15]}}, ins[15:0], 2'b00};
    if (pc[1:0] != 2'b00) begin e.npc = pc; e.mis = 1; return e; end
    case (op)
      0: if (ins[5:0] == 8) kind = 2;
         else if (ins[5:0] == 9) begin kind = 2; lk = 1; li = int'(ins[15:11]); end
      1: case (tf)
           0, 2:   begin kind = 1; c = $signed(rs) < 0; end
           1, 3:   begin kind = 1; c = $signed(rs) >= 0; end
           16, 18: begin kind = 1; lk = 1; c = $signed(rs) < 0; end
           17, 19: begin kind = 1; lk = 1; c = $signed(rs) >= 0; end
           28: if (ext) begin kind = 1; dsp = 1; c = pos >= 32; end
           default: ;
         endcase
      2: kind = 3;
      3: begin kind = 3; lk = 1; end
      4, 20: begin kind = 1; c = rs == rt; end
      5, 21: begin kind = 1; c = rs != rt; end
      6, 22: begin kind = 1; c = $signed(rs) <= 0; end
      7, 23: begin kind = 1; c = $signed(rs) > 0; end
      17: if (rf == 8) begin
            fb = (ins[20:18] == 0) ? 23 : 24 + int'(ins[20:18]);
            kind = 1; c = ins[16] ? fc[fb] : !fc[fb];
          end
      50: if (ext) begin kind = 1; c = !rs[tf]; end
      54: if (ext) begin kind = 1; c = !rs[32 + int'(tf)]; end
      58: if (ext) begin kind = 1; c = rs[tf]; end
      62: if (ext) begin kind = 1; c = rs[32 + int'(tf)]; end
      default: ;
    endcase
    if (kind == 0) begin e.inv = 1; e.npc = pc + 4; return e; end
    if (dsp && !dav) begin e.dspf = 1; e.npc = pc; return e; end
    if (kind == 2) begin e.tk = 1; e.npc = rs[31:0]; end
    else if (kind == 3) begin e.tk = 1; e.npc = {pc[31:28] + 4'd0, ins[25:0], 2'b00};
      e.npc[31:28] = (pc + 32'd4) >> 28; end
    else begin e.tk = c; e.npc = c ? pc + 4 + off : pc + 8; end
    if (lk) begin e.lwe = 1; e.lidx = 5'(li); e.lval = pc + 8; end
    return e;
  endfunction

  function automatic logic [31:0] ienc(input int op, input int rs, input int rt, input int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic drive(input logic [31:0] pc, input logic [31:0] ins, input logic [63:0] rs,
                       input logic [63:0] rt, input logic [31:0] fc, input logic [5:0] pos,
                       input bit dav, input string tag);
    @(negedge clk);
    valid_i = 1'b1; pc_i = pc; instr_i = ins; rs_i = rs; rt_i = rt;
    fcsr_i = fc; pos_i = pos; dav_i = dav;
    qa.push_back(model(1'b1, pc, ins, rs, rt, fc, pos, dav));
    qb.push_back(model(1'b0, pc, ins, rs, rt, fc, pos, dav));
    qt.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && va) begin
      exp_t ea, eb, ga, gb;
      string t;
      if (qa.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: valid_o=1 with nothing pending, expected valid_o=0");
      end else begin
        ea = qa.pop_front(); eb = qb.pop_front(); t = qt.pop_front();
        ga = '{npca, tka, lwea, lidxa, lvala, misa, dspfa, inva};
        gb = '{npcb, tkb, lweb, lidxb, lvalb, misb, dspfb, invb};
        checks++;
        if (ga !== ea) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, ga, ea);
        end
        checks++;
        if (!vb || gb !== eb) begin
          errors++;
          $display("FAIL %s (no-ext, R10): actual v=%0b %h expected %h", t, vb, gb, eb);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    checks++;
    if (va !== 1'b0 || npca !== 32'd0 || lwea !== 1'b0) begin
      errors++;
      $display("FAIL R11: reset state v=%0b npc=%h lwe=%0b expected 0 0 0", va, npca, lwea);
    end
    rst_n = 1'b1;
    idle(2);

    // R1 misaligned
    drive(32'h1002, ienc(4, 1, 2, 3), 64'd5, 64'd5, 0, 0, 1, "R1 misaligned beq");
    drive(32'h1001, {6'd3, 26'h123}, 0, 0, 0, 0, 1, "R1 misaligned jal");
    // R2/R3 compare branches
    drive(32'h1000, ienc(4, 1, 2, 16'hFFFC), 64'd7, 64'd7, 0, 0, 1, "R2 R3 beq taken back");
    drive(32'h1000, ienc(20, 1, 2, 16'h0010), 64'd7, 64'd8, 0, 0, 1, "R2 R3 beql not taken");
    drive(32'h2000, ienc(5, 1, 2, 16'h7FFF), 64'h100_0000_0000, 64'd0, 0, 0, 1, "R3 bne upper word");
    drive(32'h2000, ienc(21, 1, 2, 16'h8000), 64'h5, 64'h5, 0, 0, 1, "R3 bnel equal");
    drive(32'h3000, ienc(6, 1, 0, 16'h0020), 64'd0, 0, 0, 0, 1, "R3 blez zero");
    drive(32'h3000, ienc(7, 1, 0, 16'h0020), 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 1, "R3 bgtz negative");
    drive(32'h3000, ienc(23, 1, 0, 16'h0020), 64'd5, 0, 0, 0, 1, "R3 bgtzl positive");
    drive(32'h3000, ienc(22, 1, 0, 16'h0020), 64'd1, 0, 0, 0, 1, "R3 blezl positive");
    // R4 regimm
    drive(32'h4000, ienc(1, 1, 0, 16'h0004), 64'h8000_0000_0000_0000, 0, 0, 0, 1, "R4 bltz neg");
    drive(32'h4000, ienc(1, 1, 1, 16'h0004), 64'd0, 0, 0, 0, 1, "R4 bgez zero");
    drive(32'h4000, ienc(1, 1, 3, 16'h0004), 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 1, "R4 bgezl neg");
    drive(32'h4000, ienc(1, 1, 16, 16'hFFF0), 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 1, "R4 R12 bltzal link");
    drive(32'h4000, ienc(1, 1, 19, 16'h0040), 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 1, "R4 R12 bgezall not taken links");
    // R5 absolute jumps
    drive(32'hA000_0FFC, {6'd2, 26'h0123456}, 0, 0, 0, 0, 1, "R5 j region");
    drive(32'h9FFF_FFFC, {6'd3, 26'h3FFFFFF}, 0, 0, 0, 0, 1, "R5 R12 jal region carry");
    // R6 register jumps
    drive(32'h5000, {6'd0, 5'd4, 15'd0, 6'd8}, 64'h1_1234_5678, 0, 0, 0, 1, "R6 jr");
    drive(32'h5000, {6'd0, 5'd4, 5'd0, 5'd7, 5'd0, 6'd9}, 64'h0000_8000, 0, 0, 0, 1, "R6 R12 jalr rd7");
    // R7 fp condition
    drive(32'h6000, ienc(17, 8, 5'b00001, 16'h0008), 0, 0, 32'h0080_0000, 0, 1, "R7 cc0 true set");
    drive(32'h6000, ienc(17, 8, 5'b00000, 16'h0008), 0, 0, 32'h0080_0000, 0, 1, "R7 cc0 false set");
    drive(32'h6000, ienc(17, 8, 5'b00101, 16'h0008), 0, 0, 32'h0100_0000, 0, 1, "R7 cc1 ignores bit24");
    drive(32'h6000, ienc(17, 8, 5'b00111, 16'h0008), 0, 0, 32'h0200_0000, 0, 1, "R7 cc1 bit25 likely");
    drive(32'h6000, ienc(17, 8, 5'b11100, 16'h0008), 0, 0, 32'h7FFF_FFFF, 0, 1, "R7 cc7 false clear");
    drive(32'h6000, ienc(17, 0, 5'b00001, 16'h0008), 0, 0, 32'hFFFF_FFFF, 0, 1, "R10 cop1 not branch");
    // R8 dsp
    drive(32'h7000, ienc(1, 0, 28, 16'h0002), 0, 0, 0, 6'd32, 1, "R8 pos 32");
    drive(32'h7000, ienc(1, 0, 28, 16'h0002), 0, 0, 0, 6'd31, 1, "R8 pos 31");
    drive(32'h7000, ienc(1, 0, 28, 16'h0002), 0, 0, 0, 6'd40, 0, "R8 dsp absent");
    // R9 bit test
    drive(32'h8000, ienc(50, 1, 3, 16'h0006), 64'hFFFF_FFFF_FFFF_FFF7, 0, 0, 0, 1, "R9 low clear");
    drive(32'h8000, ienc(54, 1, 0, 16'h0006), 64'h1_0000_0000, 0, 0, 0, 1, "R9 high clear set");
    drive(32'h8000, ienc(58, 1, 31, 16'h0006), 64'h8000_0000, 0, 0, 0, 1, "R9 low set bit31");
    drive(32'h8000, ienc(62, 1, 31, 16'h0006), 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 0, 1, "R9 high set bit63");
    // R10 invalid
    drive(32'h9000, ienc(8, 1, 2, 16'h0001), 0, 0, 0, 0, 1, "R10 addi");
    drive(32'h9000, {6'd0, 20'd0, 6'h20}, 0, 0, 0, 0, 1, "R10 special other");
    drive(32'h9000, ienc(1, 1, 5, 16'h0001), 0, 0, 0, 0, 1, "R10 regimm other");
    idle(3);

    // R11 hold while idle, with inputs changing
    held = npca;
    @(negedge clk);
    pc_i = 32'hDEAD_0000; instr_i = ienc(4, 0, 0, 1);
    idle(3);
    checks++;
    if (va !== 1'b0 || npca !== held) begin
      errors++;
      $display("FAIL R11: idle hold v=%0b npc=%h expected v=0 npc=%h", va, npca, held);
    end
    checks++;
    if (qa.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d results missing, expected 0", qa.size());
    end
    finish_run();
  end
endmodule